// File: doc/BRIEF.md
# Banked CPU Register File

This block holds the architectural registers of a 16-bit processor core. Seven registers exist in two copies, called banks: four data registers, two address registers and a frame pointer. A bit in the flag register picks the bank that every access to these seven uses. The other registers exist once and are shared by both banks. They are a 20-bit program counter, a user stack pointer, an interrupt stack pointer, a static base pointer, a 20-bit interrupt vector table base and a 16-bit flag register.

Two combinational read ports and one clocked write port each take a 4-bit register selector and a 2-bit access size. The size may be the low byte, the high byte, a 16-bit word or a 32-bit long. A long access joins fixed register pairs into one 32-bit operand. A selector alias reaches whichever stack pointer the user-stack flag currently names. The execution unit can also change chosen flag bits directly through a masked update input. A request whose selector and size do not go together is dropped, and it raises an error output in the same cycle.

Top module: `bankreg_file`

## Requirements
- R1: After a synchronous active-high reset every register and every flag reads as zero. Bank 0 is therefore active and the stack alias names the interrupt stack pointer.
- R2: Selector codes are: 0-3 data registers D0-D3, 4-5 address registers A0-A1, 6 frame pointer, 7 program counter, 8 user stack pointer, 9 interrupt stack pointer, 10 static base, 11 vector table base, 12 flags, 13 stack alias, 14-15 unused. Codes 0-6 exist once per bank, and flag bit 4 selects the bank for reads and writes. Codes 7-12 are shared by both banks.
- R3: Size codes are 0 low byte, 1 high byte, 2 word, 3 long. Byte sizes on D0 and D1 reach bits 7:0 or 15:8. A byte read returns the byte in bits 7:0 with zeros above it. A byte write leaves the other byte unchanged.
- R4: A long access to D0 carries {D2,D0}, to D1 carries {D3,D1} and to A0 carries {A1,A0}, with the first-named register in bits 31:16. This holds for both reads and writes.
- R5: The vector table base is 20 bits wide. A long access carries all 20 bits in bits 19:0. A word access carries bits 15:0. A high-byte access carries bits 19:16 in data bits 3:0, and a write at that size changes only those 4 bits. The program counter is accessed by long only, as 20 bits in data bits 19:0.
- R6: Flag positions are carry 0, debug 1, zero 2, sign 3, bank 4, overflow 5, interrupt enable 6, user-stack 7, and priority level in bits 14:12. All other flag bits always read 0 and ignore writes. The flag register is also driven on flags_out.
- R7: Selector 13, accessed as a word, reaches the user stack pointer when flag bit 7 is 1 and the interrupt stack pointer when it is 0. This holds for reads and writes.
- R8: Writes take effect at the next clock edge. A read in the same cycle returns the old value. A port write in a cycle that also changes the bank flag lands in the bank that was active before that edge.
- R9: Legal pairs are: low byte on D0 or D1; high byte on D0, D1 or the table base; word on every code except 7, 14 and 15; long on D0, D1, A0, 7 and 11. Any other pair on a read port returns zero data with that port's error high. On the write port it changes nothing and raises wr_err in the same cycle.
- R10: When flg_upd_en is high, each flag bit whose mask bit is 1 takes the value bit, and the reserved bits stay 0. This update is applied over any port write to the flags in the same cycle, and the two take effect together at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd0_sel | input | 4 | Read port 0 register selector |
| rd0_size | input | 2 | Read port 0 access size |
| rd0_data | output | 32 | Read port 0 data |
| rd0_err | output | 1 | Read port 0 illegal request |
| rd1_sel | input | 4 | Read port 1 register selector |
| rd1_size | input | 2 | Read port 1 access size |
| rd1_data | output | 32 | Read port 1 data |
| rd1_err | output | 1 | Read port 1 illegal request |
| wr_en | input | 1 | Write request |
| wr_sel | input | 4 | Write register selector |
| wr_size | input | 2 | Write access size |
| wr_data | input | 32 | Write data |
| wr_err | output | 1 | Illegal write request, dropped |
| flg_upd_en | input | 1 | Direct flag update enable |
| flg_upd_mask | input | 16 | Flag bits to update |
| flg_upd_val | input | 16 | New values for masked flag bits |
| flags_out | output | 16 | Current flag register |

## Verification
Directed sequences write one value in one bank and another in the second bank. Reading the same selector under both settings of the bank flag then separates the banked registers from the shared ones. Byte writes to each half of D0 and D1, and long writes to each pair, are read back at every legal size, so that a swapped half, a wrong partner register or a clobbered neighbour byte shows up. Flag writes that arrive together with a masked direct update, or with a banked write, separate old-bank from new-bank steering and show which update has priority. A long stream of random selector and size pairs, many of them illegal, is checked every cycle against a behavioural model. That stream catches any illegal request that leaks into state or any legal one that is refused.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    localparam int WORD_W    = 16;
    localparam int LONG_W    = 32;
    localparam int ADDR_W    = 20;
    localparam int BYTE_W    = 8;
    localparam int BANKS     = 2;
    localparam int BANK_REGS = 7;
    localparam int SEL_W     = 4;
    localparam int SIZE_W    = 2;
    localparam int IDX_W     = $clog2(BANK_REGS);
    localparam int HIGH_W    = ADDR_W - WORD_W;

    // flag bit positions
    localparam int FB_C   = 0;
    localparam int FB_D   = 1;
    localparam int FB_Z   = 2;
    localparam int FB_S   = 3;
    localparam int FB_B   = 4;
    localparam int FB_O   = 5;
    localparam int FB_I   = 6;
    localparam int FB_U   = 7;
    localparam int IPL_LO = 12;
    localparam int IPL_HI = 14;

    localparam logic [WORD_W-1:0] FLAG_VALID = 16'h70FF;

    typedef enum logic [SEL_W-1:0] {
        SEL_D0  = 4'd0,
        SEL_D1  = 4'd1,
        SEL_D2  = 4'd2,
        SEL_D3  = 4'd3,
        SEL_A0  = 4'd4,
        SEL_A1  = 4'd5,
        SEL_FRM = 4'd6,
        SEL_PC  = 4'd7,
        SEL_UST = 4'd8,
        SEL_IST = 4'd9,
        SEL_SBS = 4'd10,
        SEL_ITB = 4'd11,
        SEL_FLG = 4'd12,
        SEL_STK = 4'd13,
        SEL_X14 = 4'd14,
        SEL_X15 = 4'd15
    } reg_sel_e;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BLO  = 2'd0,
        SZ_BHI  = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LONG = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [1:0]        bmask;
        logic [WORD_W-1:0] data;
    } bank_wr_t;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        acc_size_e         size;
        logic [ADDR_W-1:0] data;
    } sys_wr_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] ust;
        logic [WORD_W-1:0] ist;
        logic [WORD_W-1:0] sbs;
        logic [ADDR_W-1:0] itb;
        logic [WORD_W-1:0] flg;
    } sys_view_t;

    function automatic logic is_banked(reg_sel_e s);
        return s <= SEL_FRM;
    endfunction

    function automatic logic [IDX_W-1:0] bank_idx(reg_sel_e s);
        return s[IDX_W-1:0];
    endfunction

    function automatic reg_sel_e resolve_stk(reg_sel_e s, logic u);
        if (s == SEL_STK) return u ? SEL_UST : SEL_IST;
        return s;
    endfunction

    function automatic logic acc_legal(reg_sel_e s, acc_size_e z);
        logic ok;
        case (z)
            SZ_BLO:  ok = (s == SEL_D0) || (s == SEL_D1);
            SZ_BHI:  ok = (s == SEL_D0) || (s == SEL_D1) || (s == SEL_ITB);
            SZ_WORD: ok = !((s == SEL_PC) || (s == SEL_X14) || (s == SEL_X15));
            SZ_LONG: ok = (s == SEL_D0) || (s == SEL_D1) || (s == SEL_A0) ||
                          (s == SEL_PC) || (s == SEL_ITB);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    // second register of a long pair
    function automatic logic [IDX_W-1:0] pair_idx(reg_sel_e s);
        if (s == SEL_A0) return bank_idx(SEL_A1);
        return bank_idx(s) + IDX_W'(2);
    endfunction

endpackage

// File: rtl/bankreg_store.sv
module bankreg_store
    import bankreg_pkg::*;
#(
    parameter int NB = BANKS,
    parameter int NR = BANK_REGS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(NB)-1:0]         bank_sel,
    input  bank_wr_t                      wr_lo,
    input  bank_wr_t                      wr_hi,
    output logic [NR-1:0][WORD_W-1:0]     view
);
    localparam int BSW = $clog2(NB);

    logic [NB-1:0][NR-1:0][WORD_W-1:0] mem;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        for (genvar r = 0; r < NR; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[b][r] <= '0;
                end else if (bank_sel == BSW'(b)) begin
                    if (wr_lo.we && wr_lo.idx == IDX_W'(r)) begin
                        if (wr_lo.bmask[0]) mem[b][r][BYTE_W-1:0] <= wr_lo.data[BYTE_W-1:0];
                        if (wr_lo.bmask[1]) mem[b][r][WORD_W-1:BYTE_W] <= wr_lo.data[WORD_W-1:BYTE_W];
                    end
                    if (wr_hi.we && wr_hi.idx == IDX_W'(r)) begin
                        mem[b][r] <= wr_hi.data;
                    end
                end
            end
        end

        // R2
        idle_bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (bank_sel != BSW'(b)) |=> $stable(mem[b]));
    end

    assign view = mem[bank_sel];

endmodule

// File: rtl/bankreg_sys.sv
module bankreg_sys
    import bankreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sys_wr_t           wr,
    input  logic              upd_en,
    input  logic [WORD_W-1:0] upd_mask,
    input  logic [WORD_W-1:0] upd_val,
    output sys_view_t         view
);
    logic [ADDR_W-1:0] pc_q, itb_q;
    logic [WORD_W-1:0] ust_q, ist_q, sbs_q, flg_q;
    logic [WORD_W-1:0] flg_base, flg_next;

    always_comb begin
        flg_base = flg_q;
        if (wr.we && wr.sel == SEL_FLG) flg_base = wr.data[WORD_W-1:0];
        if (upd_en) flg_base = (flg_base & ~upd_mask) | (upd_val & upd_mask);
        flg_next = flg_base & FLAG_VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            itb_q <= '0;
            ust_q <= '0;
            ist_q <= '0;
            sbs_q <= '0;
            flg_q <= '0;
        end else begin
            if (wr.we) begin
                case (wr.sel)
                    SEL_PC:  pc_q  <= wr.data;
                    SEL_UST: ust_q <= wr.data[WORD_W-1:0];
                    SEL_IST: ist_q <= wr.data[WORD_W-1:0];
                    SEL_SBS: sbs_q <= wr.data[WORD_W-1:0];
                    SEL_ITB: begin
                        case (wr.size)
                            SZ_LONG: itb_q <= wr.data;
                            SZ_WORD: itb_q[WORD_W-1:0] <= wr.data[WORD_W-1:0];
                            SZ_BHI:  itb_q[ADDR_W-1:WORD_W] <= wr.data[HIGH_W-1:0];
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
            flg_q <= flg_next;
        end
    end

    assign view = '{pc: pc_q, ust: ust_q, ist: ist_q, sbs: sbs_q, itb: itb_q, flg: flg_q};

    // R6
    flg_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (flg_q & ~FLAG_VALID) == '0);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == '0 && itb_q == '0 && ust_q == '0 &&
                        ist_q == '0 && sbs_q == '0 && flg_q == '0));

endmodule

// File: rtl/bankreg_rdport.sv
module bankreg_rdport
    import bankreg_pkg::*;
(
    input  logic [SEL_W-1:0]                 sel_i,
    input  logic [SIZE_W-1:0]                size_i,
    input  logic [BANK_REGS-1:0][WORD_W-1:0] bview,
    input  sys_view_t                        sview,
    output logic [LONG_W-1:0]                data,
    output logic                             err
);
    reg_sel_e  s;
    acc_size_e z;

    always_comb begin
        s    = resolve_stk(reg_sel_e'(sel_i), sview.flg[FB_U]);
        z    = acc_size_e'(size_i);
        err  = !acc_legal(s, z);
        data = '0;
        if (!err) begin
            case (z)
                SZ_BLO: data[BYTE_W-1:0] = bview[bank_idx(s)][BYTE_W-1:0];
                SZ_BHI: begin
                    if (s == SEL_ITB) data[HIGH_W-1:0] = sview.itb[ADDR_W-1:WORD_W];
                    else              data[BYTE_W-1:0] = bview[bank_idx(s)][WORD_W-1:BYTE_W];
                end
                SZ_WORD: begin
                    if (is_banked(s)) begin
                        data[WORD_W-1:0] = bview[bank_idx(s)];
                    end else begin
                        case (s)
                            SEL_UST: data[WORD_W-1:0] = sview.ust;
                            SEL_IST: data[WORD_W-1:0] = sview.ist;
                            SEL_SBS: data[WORD_W-1:0] = sview.sbs;
                            SEL_ITB: data[WORD_W-1:0] = sview.itb[WORD_W-1:0];
                            SEL_FLG: data[WORD_W-1:0] = sview.flg;
                            default: ;
                        endcase
                    end
                end
                SZ_LONG: begin
                    case (s)
                        SEL_PC:  data[ADDR_W-1:0] = sview.pc;
                        SEL_ITB: data[ADDR_W-1:0] = sview.itb;
                        default: data = {bview[pair_idx(s)], bview[bank_idx(s)]};
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bankreg_wrroute.sv
module bankreg_wrroute
    import bankreg_pkg::*;
(
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [LONG_W-1:0] wr_data,
    input  logic              u_flag,
    output bank_wr_t          lo,
    output bank_wr_t          hi,
    output sys_wr_t           sys,
    output logic              err
);
    reg_sel_e  s;
    acc_size_e z;
    logic      act;

    always_comb begin
        s   = resolve_stk(reg_sel_e'(wr_sel), u_flag);
        z   = acc_size_e'(wr_size);
        err = wr_en && !acc_legal(s, z);
        act = wr_en && acc_legal(s, z);
        lo  = '0;
        hi  = '0;
        sys = '0;
        if (act && is_banked(s)) begin
            lo.we  = 1'b1;
            lo.idx = bank_idx(s);
            case (z)
                SZ_BLO: begin
                    lo.bmask = 2'b01;
                    lo.data  = {{BYTE_W{1'b0}}, wr_data[BYTE_W-1:0]};
                end
                SZ_BHI: begin
                    lo.bmask = 2'b10;
                    lo.data  = {wr_data[BYTE_W-1:0], {BYTE_W{1'b0}}};
                end
                SZ_WORD: begin
                    lo.bmask = 2'b11;
                    lo.data  = wr_data[WORD_W-1:0];
                end
                default: begin
                    lo.bmask = 2'b11;
                    lo.data  = wr_data[WORD_W-1:0];
                    hi.we    = 1'b1;
                    hi.idx   = pair_idx(s);
                    hi.data  = wr_data[LONG_W-1:WORD_W];
                end
            endcase
        end else if (act) begin
            sys.we   = 1'b1;
            sys.sel  = s;
            sys.size = z;
            sys.data = wr_data[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
    import bankreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  rd0_sel,
    input  logic [SIZE_W-1:0] rd0_size,
    output logic [LONG_W-1:0] rd0_data,
    output logic              rd0_err,
    input  logic [SEL_W-1:0]  rd1_sel,
    input  logic [SIZE_W-1:0] rd1_size,
    output logic [LONG_W-1:0] rd1_data,
    output logic              rd1_err,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [LONG_W-1:0] wr_data,
    output logic              wr_err,
    input  logic              flg_upd_en,
    input  logic [WORD_W-1:0] flg_upd_mask,
    input  logic [WORD_W-1:0] flg_upd_val,
    output logic [WORD_W-1:0] flags_out
);
    localparam int NPORTS = 2;

    logic [BANK_REGS-1:0][WORD_W-1:0] bview;
    sys_view_t                        sview;
    bank_wr_t                         bwr_lo, bwr_hi;
    sys_wr_t                          swr;

    logic [NPORTS-1:0][SEL_W-1:0]  p_sel;
    logic [NPORTS-1:0][SIZE_W-1:0] p_size;
    logic [NPORTS-1:0][LONG_W-1:0] p_data;
    logic [NPORTS-1:0]             p_err;

    assign p_sel  = {rd1_sel, rd0_sel};
    assign p_size = {rd1_size, rd0_size};

    bankreg_store #(.NB(BANKS), .NR(BANK_REGS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .bank_sel (sview.flg[FB_B]),
        .wr_lo    (bwr_lo),
        .wr_hi    (bwr_hi),
        .view     (bview)
    );

    bankreg_sys u_sys (
        .clk      (clk),
        .rst      (rst),
        .wr       (swr),
        .upd_en   (flg_upd_en),
        .upd_mask (flg_upd_mask),
        .upd_val  (flg_upd_val),
        .view     (sview)
    );

    bankreg_wrroute u_wr (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_size (wr_size),
        .wr_data (wr_data),
        .u_flag  (sview.flg[FB_U]),
        .lo      (bwr_lo),
        .hi      (bwr_hi),
        .sys     (swr),
        .err     (wr_err)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        bankreg_rdport u_rd (
            .sel_i  (p_sel[p]),
            .size_i (p_size[p]),
            .bview  (bview),
            .sview  (sview),
            .data   (p_data[p]),
            .err    (p_err[p])
        );
    end

    assign rd0_data  = p_data[0];
    assign rd1_data  = p_data[1];
    assign rd0_err   = p_err[0];
    assign rd1_err   = p_err[1];
    assign flags_out = sview.flg;

    // R9
    wr_illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_err && !flg_upd_en) |=> ($stable(sview) && $stable(bview)));

    // R8
    flag_write_next_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_err && wr_sel == SEL_FLG && !flg_upd_en) |=>
        (flags_out == ($past(wr_data[WORD_W-1:0]) & FLAG_VALID)));

    // R10
    flag_upd_mask_chk: assert property (@(posedge clk) disable iff (rst)
        flg_upd_en |=>
        (((flags_out ^ $past(flg_upd_val)) & $past(flg_upd_mask) & FLAG_VALID) == '0));

    // R9
    rd_err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd0_err || rd1_err) |-> ((rd0_err ? rd0_data : '0) | (rd1_err ? rd1_data : '0)) == '0);

endmodule

// File: tb/bankreg_file_bench.sv
`timescale 1ns/1ps
module bankreg_file_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd0_sel = '0, rd1_sel = '0, wr_sel = '0;
    logic [1:0]  rd0_size = '0, rd1_size = '0, wr_size = '0;
    logic [31:0] rd0_data, rd1_data, wr_data = '0;
    logic        rd0_err, rd1_err, wr_err;
    logic        wr_en = 1'b0, flg_upd_en = 1'b0;
    logic [15:0] flg_upd_mask = '0, flg_upd_val = '0, flags_out;

    bankreg_file u_bankreg_file (
        .clk(clk), .rst(rst),
        .rd0_sel(rd0_sel), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_sel(rd1_sel), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_err(rd1_err),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
        .flg_upd_en(flg_upd_en), .flg_upd_mask(flg_upd_mask), .flg_upd_val(flg_upd_val),
        .flags_out(flags_out)
    );

    always #2 clk = ~clk;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string cur_req = "R1";

    bit [31:0] mb [2][7];
    bit [31:0] m_pc = 0, m_ust = 0, m_ist = 0, m_sbs = 0, m_itb = 0, m_flg = 0;

    function automatic int rsv(int s);
        if (s == 13) return m_flg[7] ? 8 : 9;
        return s;
    endfunction

    function automatic bit [31:0] mread(int s0, int z, output bit ok);
        int s = rsv(s0);
        int b = int'(m_flg[4]);
        bit [31:0] d = 0;
        ok = 0;
        if (z == 0 && s <= 1) begin ok = 1; d = mb[b][s] & 32'hFF; end
        else if (z == 1 && s <= 1) begin ok = 1; d = (mb[b][s] >> 8) & 32'hFF; end
        else if (z == 1 && s == 11) begin ok = 1; d = (m_itb >> 16) & 32'hF; end
        else if (z == 2 && s <= 6) begin ok = 1; d = mb[b][s]; end
        else if (z == 2 && s == 8) begin ok = 1; d = m_ust; end
        else if (z == 2 && s == 9) begin ok = 1; d = m_ist; end
        else if (z == 2 && s == 10) begin ok = 1; d = m_sbs; end
        else if (z == 2 && s == 11) begin ok = 1; d = m_itb & 32'hFFFF; end
        else if (z == 2 && s == 12) begin ok = 1; d = m_flg; end
        else if (z == 3 && (s == 0 || s == 1)) begin ok = 1; d = (mb[b][s+2] << 16) | mb[b][s]; end
        else if (z == 3 && s == 4) begin ok = 1; d = (mb[b][5] << 16) | mb[b][4]; end
        else if (z == 3 && s == 7) begin ok = 1; d = m_pc; end
        else if (z == 3 && s == 11) begin ok = 1; d = m_itb; end
        return d;
    endfunction

    task automatic mupdate(bit we, int ws, int wz, bit [31:0] wd, bit fe, bit [15:0] fm, bit [15:0] fv);
        bit ok;
        bit [31:0] nf = m_flg;
        int s = rsv(ws);
        int b = int'(m_flg[4]);
        bit [31:0] unused_d = mread(ws, wz, ok);
        if (unused_d == 32'hDEAD_0000) ok = ok;
        if (we && ok) begin
            if (s <= 6) begin
                case (wz)
                    0: mb[b][s] = (mb[b][s] & 32'hFF00) | (wd & 32'hFF);
                    1: mb[b][s] = (mb[b][s] & 32'h00FF) | ((wd & 32'hFF) << 8);
                    2: mb[b][s] = wd & 32'hFFFF;
                    default: begin
                        mb[b][s] = wd & 32'hFFFF;
                        mb[b][(s == 4) ? 5 : s + 2] = wd >> 16;
                    end
                endcase
            end else begin
                case (s)
                    7:  m_pc  = wd & 32'hFFFFF;
                    8:  m_ust = wd & 32'hFFFF;
                    9:  m_ist = wd & 32'hFFFF;
                    10: m_sbs = wd & 32'hFFFF;
                    11: begin
                        if (wz == 3)      m_itb = wd & 32'hFFFFF;
                        else if (wz == 2) m_itb = (m_itb & 32'hF0000) | (wd & 32'hFFFF);
                        else              m_itb = (m_itb & 32'hFFFF) | ((wd & 32'hF) << 16);
                    end
                    12: nf = wd & 32'hFFFF;
                    default: ;
                endcase
            end
        end
        if (fe) nf = (nf & ~{16'h0, fm}) | ({16'h0, fv} & {16'h0, fm});
        m_flg = nf & 32'h70FF;
    endtask

    task automatic chk(string req, string what, bit [31:0] act, bit [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(int r0s, int r0z, int r1s, int r1z, bit we, int ws, int wz,
                        bit [31:0] wd, bit fe, bit [15:0] fm, bit [15:0] fv);
        bit ok0, ok1, okw;
        bit [31:0] e0, e1, ew;
        @(negedge clk);
        rd0_sel = 4'(r0s); rd0_size = 2'(r0z);
        rd1_sel = 4'(r1s); rd1_size = 2'(r1z);
        wr_en = we; wr_sel = 4'(ws); wr_size = 2'(wz); wr_data = wd;
        flg_upd_en = fe; flg_upd_mask = fm; flg_upd_val = fv;
        #1;
        e0 = mread(r0s, r0z, ok0);
        e1 = mread(r1s, r1z, ok1);
        ew = mread(ws, wz, okw);
        chk(cur_req, "rd0_data", rd0_data, e0);
        chk(cur_req, "rd0_err", 32'(rd0_err), 32'(!ok0));
        chk(cur_req, "rd1_data", rd1_data, e1);
        chk(cur_req, "rd1_err", 32'(rd1_err), 32'(!ok1));
        chk(cur_req, "wr_err", 32'(wr_err), 32'(we && !okw));
        chk(cur_req, "flags_out", 32'(flags_out), m_flg);
        if (ew == 32'hDEAD_0001) ok0 = 0;
        @(posedge clk);
        mupdate(we, ws, wz, wd, fe, fm, fv);
    endtask

    task automatic wr(int ws, int wz, bit [31:0] wd);
        step(ws, wz, 12, 2, 1'b1, ws, wz, wd, 1'b0, 16'h0, 16'h0);
    endtask

    task automatic rd(int s0, int z0, int s1, int z1);
        step(s0, z0, s1, z1, 1'b0, 0, 0, 0, 1'b0, 16'h0, 16'h0);
    endtask

    task automatic peek(string req, int s, int z, bit [31:0] exp);
        @(negedge clk);
        wr_en = 0; flg_upd_en = 0; rd0_sel = 4'(s); rd0_size = 2'(z);
        #1;
        chk(req, "const rd0_data", rd0_data, exp);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 7; r++) mb[b][r] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset values, stack alias on interrupt pointer
        cur_req = "R1";
        for (int s = 0; s < 14; s++) rd(s, 2, s, 3);
        peek("R1", 12, 2, 32'h0);

        // R2 banking
        cur_req = "R2";
        wr(0, 2, 32'hA5A5);
        wr(10, 2, 32'h1111);
        wr(12, 2, 32'h0010);
        rd(0, 2, 10, 2);
        wr(0, 2, 32'h5A5A);
        wr(6, 2, 32'h6666);
        peek("R2", 0, 2, 32'h5A5A);
        wr(12, 2, 32'h0000);
        rd(0, 2, 6, 2);
        peek("R2", 0, 2, 32'hA5A5);
        peek("R2", 10, 2, 32'h1111);

        // R3 byte halves
        cur_req = "R3";
        wr(1, 2, 32'h1234);
        wr(1, 0, 32'hFFFF_FFCD);
        wr(1, 1, 32'h0000_00AB);
        rd(1, 0, 1, 1);
        peek("R3", 1, 2, 32'hABCD);
        peek("R3", 1, 1, 32'h00AB);

        // R4 long pairs
        cur_req = "R4";
        wr(0, 2, 32'h5678);
        wr(2, 2, 32'h1234);
        peek("R4", 0, 3, 32'h12345678);
        wr(1, 3, 32'hDEAD_BEEF);
        wr(4, 3, 32'hCAFE_F00D);
        rd(3, 2, 5, 2);
        peek("R4", 5, 2, 32'hCAFE);
        peek("R4", 1, 2, 32'hBEEF);

        // R5 table base and program counter
        cur_req = "R5";
        wr(11, 3, 32'hFFF_ABCDE);
        rd(11, 1, 11, 2);
        wr(11, 1, 32'h0000_0003);
        wr(11, 2, 32'h0000_7777);
        peek("R5", 11, 3, 32'h0003_7777);
        wr(7, 3, 32'hFFFF_FFFF);
        peek("R5", 7, 3, 32'h000F_FFFF);

        // R6 flag layout
        cur_req = "R6";
        wr(12, 2, 32'hFFFF_FFFF);
        peek("R6", 12, 2, 32'h70FF);
        wr(12, 2, 32'h0000_0000);

        // R7 stack alias
        cur_req = "R7";
        wr(8, 2, 32'h0888);
        wr(9, 2, 32'h0999);
        peek("R7", 13, 2, 32'h0999);
        wr(12, 2, 32'h0080);
        peek("R7", 13, 2, 32'h0888);
        wr(13, 2, 32'h0ABC);
        rd(8, 2, 9, 2);
        wr(12, 2, 32'h0000);

        // R8 same-cycle ordering: write lands in old bank
        cur_req = "R8";
        step(0, 2, 12, 2, 1'b1, 0, 2, 32'hBEEF, 1'b1, 16'h0010, 16'h0010);
        rd(0, 2, 12, 2);
        wr(12, 2, 32'h0000);
        peek("R8", 0, 2, 32'hBEEF);

        // R9 illegal requests
        cur_req = "R9";
        wr(4, 0, 32'h1);
        wr(2, 3, 32'h2);
        wr(7, 2, 32'h3);
        wr(14, 2, 32'h4);
        wr(6, 1, 32'h5);
        wr(12, 3, 32'hFFFF);
        rd(2, 0, 15, 3);
        rd(6, 3, 8, 1);

        // R10 masked flag update over a port write
        cur_req = "R10";
        step(12, 2, 0, 2, 1'b1, 12, 2, 32'h00FF, 1'b1, 16'h00F0, 16'h3000);
        rd(12, 2, 0, 2);
        step(12, 2, 0, 2, 1'b0, 0, 0, 0, 1'b1, 16'h7000, 16'hFFFF);
        peek("R10", 12, 2, 32'h700F);

        // random mix
        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            step(int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
                 $urandom, ($urandom_range(0, 7) == 0),
                 16'($urandom), 16'($urandom));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule